// File: doc/BRIEF.md
# Layer-2 Address-Learning Forwarding Engine

This block makes the forwarding decision for a small multi-port Ethernet layer-2 switch. Each accepted request carries one frame header: the port the frame arrived on, its destination MAC and its source MAC. The engine searches a small fully associative address table for the destination. In the same cycle it learns the source address against the arrival port. One cycle after acceptance it presents a registered egress port mask and a drop flag. The engine works only on MAC addresses. It takes no part in address resolution and never looks above layer 2.

Broadcast frames are sent to every port. A known unicast destination goes to the single port learned for it. An unknown unicast destination is dropped, unless a configuration input selects flooding. Multicast destinations are forwarded only to ports whose receivers have joined that group, using a separate group table written through a simple group-write port. The arrival port is always removed from the egress mask.

Top module: `l2_fwd_engine`

## Requirements
- R1: After reset `reqReady` is high, `rspValid` is low and `rspMask` is zero. `rspValid` goes high exactly one cycle after each accepted request and is low otherwise. While `rspValid` is low, mask and drop are zero.
- R2: A destination of all ones (broadcast) yields a mask of every port except the arrival port.
- R3: A request from port p with unicast source S causes a later request with destination S to be sent only to port p.
- R4: With `cfgFloodUnknown` low, a unicast destination absent from the table yields mask zero and `rspDrop` high.
- R5: With `cfgFloodUnknown` high, a unicast destination absent from the table yields every port except the arrival port.
- R6: A destination is multicast when bit 40 (bit 0 of the first transmitted octet, with octets packed most significant first) is 1 and it is not broadcast. A multicast destination yields the subscribed port mask of its group, minus the arrival port. With no subscription it is dropped.
- R7: The arrival port never appears in the mask. A frame whose learned destination is its own arrival port is dropped.
- R8: A known source seen on a different port has its table entry moved to the new port.
- R9: A new source goes to the lowest free entry. When the table is full, entries are replaced in round-robin order starting at entry 0.
- R10: A source with bit 40 set (multicast or broadcast) is never learned and occupies no entry.
- R11: Lookup uses the table as it was before the same request's source is learned. A frame whose destination equals its own unknown source is treated as unknown.
- R12: A group write with a nonzero mask sets that group's subscription, and a zero mask removes it. A multicast lookup in the same cycle as a group write sees the subscription from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFloodUnknown | input | 1 | 1 floods unknown unicast, 0 drops it |
| reqValid | input | 1 | Header request present |
| reqReady | output | 1 | Engine accepts a request this cycle |
| reqPort | input | PORT_W | Arrival port number |
| reqDst | input | 48 | Destination MAC, first octet in bits 47:40 |
| reqSrc | input | 48 | Source MAC, first octet in bits 47:40 |
| grpWrEn | input | 1 | Group subscription write strobe |
| grpWrMac | input | 48 | Group MAC being written |
| grpWrMask | input | NUM_PORTS | Subscribed ports; zero removes the group |
| rspValid | output | 1 | Result valid |
| rspMask | output | NUM_PORTS | Egress port mask |
| rspDrop | output | 1 | Frame is dropped (mask empty) |

## Verification
Two functions can fall in the same cycle, and the bench makes both collide. The first is learning and lookup: a header whose destination equals its own not-yet-known source must come back as unknown. A following request must then find that address learned. The second is a group write and a multicast lookup: the bench drives both on the same clock edge for the same group. It expects the old subscription in that result and the new one in the next.

// File: rtl/l2fwd_pkg.sv
package l2fwd_pkg;
  localparam int unsigned MAC_W = 48;
  localparam int unsigned GRP_BIT = MAC_W - 8;

  typedef enum logic [1:0] {
    SEL_HIT    = 2'd0,
    SEL_FREE   = 2'd1,
    SEL_VICTIM = 2'd2
  } slotSel_e;

  typedef struct packed {
    logic     learnWr;
    slotSel_e learnSel;
    logic     grpWr;
    logic     grpUseHit;
    logic     grpKeep;
  } ctlStrb_t;
endpackage

// File: rtl/l2fwd_dp.sv
module l2fwd_dp
  import l2fwd_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned GRP_DEPTH = 4,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int unsigned GIDX_W = (GRP_DEPTH > 1) ? $clog2(GRP_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrb_t             strb,
  input  logic [IDX_W-1:0]     victimIdx,
  input  logic [MAC_W-1:0]     dstMac,
  input  logic [MAC_W-1:0]     lrnMac,
  input  logic [PORT_W-1:0]    lrnPort,
  input  logic [MAC_W-1:0]     grpWrMac,
  input  logic [NUM_PORTS-1:0] grpWrMask,
  output logic                 dstHit,
  output logic [PORT_W-1:0]    dstPort,
  output logic                 srcHit,
  output logic                 freeAvail,
  output logic                 grpHit,
  output logic [NUM_PORTS-1:0] grpMask,
  output logic                 grpWrHit,
  output logic                 grpFreeAvail
);
  logic                 tblVal  [TBL_DEPTH];
  logic [MAC_W-1:0]     tblMac  [TBL_DEPTH];
  logic [PORT_W-1:0]    tblPort [TBL_DEPTH];
  logic                 grpVal  [GRP_DEPTH];
  logic [MAC_W-1:0]     grpMac  [GRP_DEPTH];
  logic [NUM_PORTS-1:0] grpMsk  [GRP_DEPTH];

  logic [TBL_DEPTH-1:0] dstMatch, srcMatch;
  logic [GRP_DEPTH-1:0] gDstMatch, gWrMatch;
  logic [IDX_W-1:0]     srcIdx, freeIdx, lrnIdx;
  logic [GIDX_W-1:0]    gWrIdx, gFreeIdx, gIdx;

  // Parallel compare of every entry against both addresses
  for (genvar e = 0; e < TBL_DEPTH; e++) begin : gTblCmp
    assign dstMatch[e] = tblVal[e] && (tblMac[e] == dstMac);
    assign srcMatch[e] = tblVal[e] && (tblMac[e] == lrnMac);
  end

  for (genvar e = 0; e < GRP_DEPTH; e++) begin : gGrpCmp
    assign gDstMatch[e] = grpVal[e] && (grpMac[e] == dstMac);
    assign gWrMatch[e]  = grpVal[e] && (grpMac[e] == grpWrMac);
  end

  // Lowest-index encoders
  always_comb begin
    dstHit    = |dstMatch;
    srcHit    = |srcMatch;
    dstPort   = '0;
    srcIdx    = '0;
    freeIdx   = '0;
    freeAvail = 1'b0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (dstMatch[i]) dstPort = tblPort[i];
      if (srcMatch[i]) srcIdx = IDX_W'(i);
      if (!tblVal[i]) begin
        freeIdx   = IDX_W'(i);
        freeAvail = 1'b1;
      end
    end
  end

  always_comb begin
    grpHit       = |gDstMatch;
    grpWrHit     = |gWrMatch;
    grpMask      = '0;
    gWrIdx       = '0;
    gFreeIdx     = '0;
    grpFreeAvail = 1'b0;
    for (int i = GRP_DEPTH - 1; i >= 0; i--) begin
      if (gDstMatch[i]) grpMask = grpMsk[i];
      if (gWrMatch[i]) gWrIdx = GIDX_W'(i);
      if (!grpVal[i]) begin
        gFreeIdx     = GIDX_W'(i);
        grpFreeAvail = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (strb.learnSel)
      SEL_HIT:  lrnIdx = srcIdx;
      SEL_FREE: lrnIdx = freeIdx;
      default:  lrnIdx = victimIdx;
    endcase
    gIdx = strb.grpUseHit ? gWrIdx : gFreeIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        tblVal[i]  <= 1'b0;
        tblMac[i]  <= '0;
        tblPort[i] <= '0;
      end
    end else if (strb.learnWr) begin
      tblVal[lrnIdx]  <= 1'b1;
      tblMac[lrnIdx]  <= lrnMac;
      tblPort[lrnIdx] <= lrnPort;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GRP_DEPTH; i++) begin
        grpVal[i] <= 1'b0;
        grpMac[i] <= '0;
        grpMsk[i] <= '0;
      end
    end else if (strb.grpWr) begin
      grpVal[gIdx] <= strb.grpKeep;
      grpMac[gIdx] <= grpWrMac;
      grpMsk[gIdx] <= grpWrMask;
    end
  end
endmodule

// File: rtl/l2fwd_ctrl.sv
module l2fwd_ctrl
  import l2fwd_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgFloodUnknown,
  input  logic                 reqValid,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic [MAC_W-1:0]     reqDst,
  input  logic [MAC_W-1:0]     reqSrc,
  input  logic                 grpWrEn,
  input  logic [NUM_PORTS-1:0] grpWrMask,
  input  logic                 dstHit,
  input  logic [PORT_W-1:0]    dstPort,
  input  logic                 srcHit,
  input  logic                 freeAvail,
  input  logic                 grpHit,
  input  logic [NUM_PORTS-1:0] grpMask,
  input  logic                 grpWrHit,
  input  logic                 grpFreeAvail,
  output ctlStrb_t             strb,
  output logic [IDX_W-1:0]     victimIdx,
  output logic                 reqReady,
  output logic                 rspValid,
  output logic [NUM_PORTS-1:0] rspMask,
  output logic                 rspDrop
);
  localparam logic [NUM_PORTS-1:0] ALL_PORTS = '1;
  localparam logic [NUM_PORTS-1:0] ONE_PORT  = {{(NUM_PORTS-1){1'b0}}, 1'b1};
  localparam logic [IDX_W-1:0]     LAST_IDX  = IDX_W'(TBL_DEPTH - 1);

  logic                 readyQ;
  logic                 accept;
  logic                 isBcast, isMcast;
  logic [NUM_PORTS-1:0] fwdRaw, fwdMask;

  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  // Forwarding decision, made against the table before this header learns
  always_comb begin
    isBcast = &reqDst;
    isMcast = reqDst[GRP_BIT] && !isBcast;
    if (isBcast)      fwdRaw = ALL_PORTS;
    else if (isMcast) fwdRaw = grpHit ? grpMask : '0;
    else if (dstHit)  fwdRaw = ONE_PORT << dstPort;
    else              fwdRaw = cfgFloodUnknown ? ALL_PORTS : '0;
    fwdMask = fwdRaw & ~(ONE_PORT << reqPort);
  end

  // Strobes to the datapath: source learning and group table writes
  always_comb begin
    strb = '0;
    strb.learnSel = SEL_HIT;
    if (accept && !reqSrc[GRP_BIT]) begin
      strb.learnWr = 1'b1;
      if (srcHit)         strb.learnSel = SEL_HIT;
      else if (freeAvail) strb.learnSel = SEL_FREE;
      else                strb.learnSel = SEL_VICTIM;
    end
    if (grpWrEn) begin
      if (grpWrHit) begin
        strb.grpWr     = 1'b1;
        strb.grpUseHit = 1'b1;
        strb.grpKeep   = |grpWrMask;
      end else if ((|grpWrMask) && grpFreeAvail) begin
        strb.grpWr   = 1'b1;
        strb.grpKeep = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      rspValid  <= 1'b0;
      rspMask   <= '0;
      rspDrop   <= 1'b0;
      victimIdx <= '0;
    end else begin
      readyQ   <= 1'b1;
      rspValid <= accept;
      rspMask  <= accept ? fwdMask : '0;
      rspDrop  <= accept && (fwdMask == '0);
      if (strb.learnWr && strb.learnSel == SEL_VICTIM)
        victimIdx <= (victimIdx == LAST_IDX) ? '0 : victimIdx + 1'b1;
    end
  end
endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine
  import l2fwd_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned GRP_DEPTH = 4,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgFloodUnknown,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic [47:0]          reqDst,
  input  logic [47:0]          reqSrc,
  input  logic                 grpWrEn,
  input  logic [47:0]          grpWrMac,
  input  logic [NUM_PORTS-1:0] grpWrMask,
  output logic                 rspValid,
  output logic [NUM_PORTS-1:0] rspMask,
  output logic                 rspDrop
);
  localparam int unsigned IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

  ctlStrb_t             strb;
  logic [IDX_W-1:0]     victimIdx;
  logic                 dstHit, srcHit, freeAvail;
  logic [PORT_W-1:0]    dstPort;
  logic                 grpHit, grpWrHit, grpFreeAvail;
  logic [NUM_PORTS-1:0] grpMask;

  l2fwd_ctrl #(.NUM_PORTS(NUM_PORTS), .TBL_DEPTH(TBL_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgFloodUnknown(cfgFloodUnknown),
    .reqValid(reqValid), .reqPort(reqPort), .reqDst(reqDst), .reqSrc(reqSrc),
    .grpWrEn(grpWrEn), .grpWrMask(grpWrMask),
    .dstHit(dstHit), .dstPort(dstPort), .srcHit(srcHit), .freeAvail(freeAvail),
    .grpHit(grpHit), .grpMask(grpMask), .grpWrHit(grpWrHit),
    .grpFreeAvail(grpFreeAvail),
    .strb(strb), .victimIdx(victimIdx), .reqReady(reqReady),
    .rspValid(rspValid), .rspMask(rspMask), .rspDrop(rspDrop)
  );

  l2fwd_dp #(.NUM_PORTS(NUM_PORTS), .TBL_DEPTH(TBL_DEPTH), .GRP_DEPTH(GRP_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .victimIdx(victimIdx),
    .dstMac(reqDst), .lrnMac(reqSrc), .lrnPort(reqPort),
    .grpWrMac(grpWrMac), .grpWrMask(grpWrMask),
    .dstHit(dstHit), .dstPort(dstPort), .srcHit(srcHit), .freeAvail(freeAvail),
    .grpHit(grpHit), .grpMask(grpMask), .grpWrHit(grpWrHit),
    .grpFreeAvail(grpFreeAvail)
  );
endmodule

// File: rtl/l2fwd_chk.sv
module l2fwd_chk #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [PORT_W-1:0]    reqPort,
  input logic [47:0]          reqDst,
  input logic                 rspValid,
  input logic [NUM_PORTS-1:0] rspMask,
  input logic                 rspDrop
);
  localparam logic [NUM_PORTS-1:0] ALL_PORTS = '1;
  localparam logic [NUM_PORTS-1:0] ONE_PORT  = {{(NUM_PORTS-1){1'b0}}, 1'b1};

  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspMask == '0 && !rspDrop));

  assert_bcast_flood_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (&reqDst)) |=>
      (rspMask == (ALL_PORTS & ~(ONE_PORT << $past(reqPort)))));

  assert_ingress_excluded_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !rspMask[$past(reqPort)]);
endmodule

bind l2_fwd_engine l2fwd_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqPort(reqPort), .reqDst(reqDst), .rspValid(rspValid),
  .rspMask(rspMask), .rspDrop(rspDrop)
);

// File: tb/l2_fwd_engine_tb_top.sv
`timescale 1ns/1ps
module l2_fwd_engine_tb_top;
  localparam int NP = 4;

  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MA = 48'h02_00_00_00_00_0A;
  localparam logic [47:0] MB = 48'h02_00_00_00_00_0B;
  localparam logic [47:0] MC = 48'h02_00_00_00_00_0C;
  localparam logic [47:0] MD = 48'h02_00_00_00_00_0D;
  localparam logic [47:0] ME = 48'h02_00_00_00_00_0E;
  localparam logic [47:0] MF = 48'h02_00_00_00_00_0F;
  localparam logic [47:0] MS = 48'h02_00_00_00_00_77;
  localparam logic [47:0] MG = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MM = 48'h03_00_00_00_00_99;

  typedef struct packed {
    logic [1:0]  port;
    logic [47:0] dst;
    logic [47:0] src;
    logic        flood;
    logic [3:0]  mask;
    logic        drop;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, BC, MA, 1'b0, 4'b1110, 1'b0},  // R2 broadcast
    '{2'd1, MA, MB, 1'b0, 4'b0001, 1'b0},  // R3 learned A on 0
    '{2'd2, MD, MC, 1'b0, 4'b0000, 1'b1},  // R4 unknown dropped
    '{2'd3, MB, MD, 1'b0, 4'b0010, 1'b0},  // R3 learned B on 1
    '{2'd2, MC, MF, 1'b0, 4'b0000, 1'b1},  // R7 dest on arrival port
    '{2'd3, MA, MA, 1'b0, 4'b0001, 1'b0},  // R11 old entry used, A moves to 3
    '{2'd1, MA, MB, 1'b0, 4'b1000, 1'b0},  // R8 station move
    '{2'd0, MG, MA, 1'b0, 4'b0000, 1'b1},  // R6 no subscriber
    '{2'd0, ME, MA, 1'b1, 4'b1110, 1'b0}   // R5 flood unknown
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgFloodUnknown = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqPort = '0;
  logic [47:0]   reqDst = '0;
  logic [47:0]   reqSrc = '0;
  logic          grpWrEn = 1'b0;
  logic [47:0]   grpWrMac = '0;
  logic [NP-1:0] grpWrMask = '0;
  logic          rspValid;
  logic [NP-1:0] rspMask;
  logic          rspDrop;

  int checks = 0;
  int failures = 0;
  logic          gotV;
  logic [NP-1:0] gotM;
  logic          gotD;

  always #5 clk = ~clk;

  l2_fwd_engine #(.NUM_PORTS(NP), .TBL_DEPTH(16), .GRP_DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .cfgFloodUnknown(cfgFloodUnknown),
    .reqValid(reqValid), .reqReady(reqReady), .reqPort(reqPort),
    .reqDst(reqDst), .reqSrc(reqSrc), .grpWrEn(grpWrEn),
    .grpWrMac(grpWrMac), .grpWrMask(grpWrMask),
    .rspValid(rspValid), .rspMask(rspMask), .rspDrop(rspDrop)
  );

  task automatic chk(input string tag, input logic v, input logic [NP-1:0] m,
                     input logic d, input logic ev, input logic [NP-1:0] em,
                     input logic ed);
    checks++;
    if (v !== ev || m !== em || d !== ed) begin
      failures++;
      $display("FAIL %s: valid=%b mask=%b drop=%b, expected valid=%b mask=%b drop=%b",
               tag, v, m, d, ev, em, ed);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // One request, optionally with a group write on the same edge
  task automatic doReq(input logic [1:0] p, input logic [47:0] d,
                       input logic [47:0] s, input logic fl,
                       input logic gw, input logic [47:0] gm,
                       input logic [NP-1:0] gk);
    @(negedge clk);
    reqValid = 1'b1; reqPort = p; reqDst = d; reqSrc = s;
    cfgFloodUnknown = fl;
    grpWrEn = gw; grpWrMac = gm; grpWrMask = gk;
    @(negedge clk);
    reqValid = 1'b0; grpWrEn = 1'b0;
    gotV = rspValid; gotM = rspMask; gotD = rspDrop;
  endtask

  task automatic grpWrite(input logic [47:0] gm, input logic [NP-1:0] gk);
    @(negedge clk);
    grpWrEn = 1'b1; grpWrMac = gm; grpWrMask = gk;
    @(negedge clk);
    grpWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 reset", rspValid, rspMask, rspDrop, 1'b0, '0, 1'b0);
    checks++;
    if (reqReady !== 1'b1) begin
      failures++;
      $display("FAIL R1 ready: got %b expected 1", reqReady);
    end

    for (int i = 0; i < NV; i++) begin
      doReq(VEC[i].port, VEC[i].dst, VEC[i].src, VEC[i].flood, 1'b0, '0, '0);
      chk($sformatf("vector %0d", i), gotV, gotM, gotD, 1'b1, VEC[i].mask, VEC[i].drop);
    end

    // R1 valid drops one cycle after the last request
    @(negedge clk);
    chk("R1 idle after response", rspValid, rspMask, rspDrop, 1'b0, '0, 1'b0);

    // R6 subscription honoured
    grpWrite(MG, 4'b0110);
    doReq(2'd1, MG, MM, 1'b0, 1'b0, '0, '0);
    chk("R6 group mask", gotV, gotM, gotD, 1'b1, 4'b0100, 1'b0);
    // R12 write and lookup on the same edge: old subscription used
    doReq(2'd0, MG, MM, 1'b0, 1'b1, MG, 4'b1001);
    chk("R12 same-cycle old", gotV, gotM, gotD, 1'b1, 4'b0110, 1'b0);
    doReq(2'd2, MG, MM, 1'b0, 1'b0, '0, '0);
    chk("R12 new subscription", gotV, gotM, gotD, 1'b1, 4'b1001, 1'b0);
    grpWrite(MG, 4'b0000);
    doReq(2'd1, MG, MM, 1'b0, 1'b0, '0, '0);
    chk("R12 cleared group", gotV, gotM, gotD, 1'b1, 4'b0000, 1'b1);

    // R11 destination equals own unknown source
    doReset();
    doReq(2'd1, MS, MS, 1'b0, 1'b0, '0, '0);
    chk("R11 self unknown", gotV, gotM, gotD, 1'b1, 4'b0000, 1'b1);
    doReq(2'd2, MS, MM, 1'b0, 1'b0, '0, '0);
    chk("R11 learned after", gotV, gotM, gotD, 1'b1, 4'b0010, 1'b0);

    // R9 / R10 table fill and round-robin replacement
    doReset();
    for (int i = 0; i < 15; i++)
      doReq(2'd0, BC, 48'h02_00_00_00_10_00 + 48'(i), 1'b0, 1'b0, '0, '0);
    doReq(2'd0, BC, MM, 1'b0, 1'b0, '0, '0);           // multicast source
    doReq(2'd0, BC, 48'h02_00_00_00_10_0F, 1'b0, 1'b0, '0, '0);
    doReq(2'd1, 48'h02_00_00_00_10_00, MM, 1'b0, 1'b0, '0, '0);
    chk("R10 mcast source not stored", gotV, gotM, gotD, 1'b1, 4'b0001, 1'b0);
    doReq(2'd0, BC, 48'h02_00_00_00_10_10, 1'b0, 1'b0, '0, '0);
    doReq(2'd1, 48'h02_00_00_00_10_00, MM, 1'b0, 1'b0, '0, '0);
    chk("R9 entry 0 replaced", gotV, gotM, gotD, 1'b1, 4'b0000, 1'b1);
    doReq(2'd1, 48'h02_00_00_00_10_01, MM, 1'b0, 1'b0, '0, '0);
    chk("R9 entry 1 kept", gotV, gotM, gotD, 1'b1, 4'b0001, 1'b0);
    doReq(2'd0, BC, 48'h02_00_00_00_10_11, 1'b0, 1'b0, '0, '0);
    doReq(2'd1, 48'h02_00_00_00_10_01, MM, 1'b0, 1'b0, '0, '0);
    chk("R9 entry 1 replaced next", gotV, gotM, gotD, 1'b1, 4'b0000, 1'b1);
    doReq(2'd1, 48'h02_00_00_00_10_02, MM, 1'b0, 1'b0, '0, '0);
    chk("R9 entry 2 kept", gotV, gotM, gotD, 1'b1, 4'b0001, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule